// File: doc/BRIEF.md
# Watchdog Timer with Oscillator Stabilization Wait

This block holds one up-counter, clocked by the system clock, that serves two purposes in turn. After the reset input is released, or after the STOP status input falls, the counter first times an oscillator settling delay. When that delay has run out, the block raises a ready flag. The same counter then keeps running, without a restart, as a software watchdog.

While the watchdog is enabled, the first overflow of the selected tap raises a one-cycle interrupt pulse. If a second overflow follows and software has not written the clear code in between, the block raises a reset request. The reset request stays high until the external reset is applied.

Software controls the block through two write-only registers. The watchdog control register holds the enable bit, the timeout select and the clear field. The delay register holds the settling-wait select.

Top module: `wdog_osc_wait`

## Requirements
- R1: The counter starts from zero after reset release or after STOP falls, and it advances by one on every clock edge. After the first edge it holds 1. The HALT input has no effect on counting or on any output timing.
- R2: The delay register is 3 bits wide and resets to 0. With delay select s, let the tap be k = DLY_BASE + TAP_STEP*min(s,5); select values 6 and 7 act as 5. `osc_ready` rises in the cycle after the counter holds 2^k. It then stays high until reset or STOP.
- R3: While `osc_ready` is low, no interrupt and no reset request are produced. The counter is not restarted when the wait ends.
- R4: The watchdog tap is w = WD_BASE + TAP_STEP*sel, where sel is `wdc_wdata[4:3]`. An overflow is a counter value that has bit w set and all lower bits clear.
- R5: The first overflow with no overflow pending gives `wd_irq` high for exactly one cycle. This is the cycle after the counter holds the overflow value. The overflow then becomes pending.
- R6: An overflow while one is already pending sets `sys_rst_req` in the next cycle. It stays high until `rst_n` is low.
- R7: A control write with `wdc_wdata[2:0]` equal to 3'b101 sets the counter to zero at that edge and clears the pending overflow. Any other code in that field leaves both unchanged.
- R8: The enable bit is `wdc_wdata[5]` and resets to 0. While it is 0, no overflow produces an interrupt or a reset request.
- R9: While STOP is high, the counter is held at zero, `osc_ready` and `wd_irq` are low, and the pending overflow is cleared. When STOP falls, a new settling wait begins.
- R10: While `rst_n` is low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| stop | input | 1 | STOP mode status, high while stopped |
| halt | input | 1 | HALT mode status |
| wdc_wr | input | 1 | Write strobe for the watchdog control register |
| wdc_wdata | input | 6 | [5] enable, [4:3] timeout select, [2:0] clear field |
| dly_wr | input | 1 | Write strobe for the delay register |
| dly_wdata | input | 3 | Settling-wait select |
| osc_ready | output | 1 | High once the settling wait has ended |
| wd_irq | output | 1 | One-cycle watchdog interrupt pulse |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
A counter that is off by one shifts `osc_ready`, `wd_irq` and `sys_rst_req` by a cycle or more from their computed times, and this shows at the first event after a release. A pending flag that is lost or never cleared shows at the second overflow. There, an interrupt appears where a reset request was due, or the reverse, about two watchdog periods after the wait. A wrong phase state shows as interrupts during the wait, or as a late or missing ready flag after STOP.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [2:0] WDC_CLR_CODE = 3'b101;
  localparam int unsigned DLY_SEL_MAX = 5;

  // true when bit k has just turned on: bit k set, all lower bits clear
  function automatic logic tap_rise(input logic [31:0] c, input int unsigned k);
    logic [31:0] low_mask;
    low_mask = (32'd1 << k) - 32'd1;
    return c[k] && ((c & low_mask) == 32'd0);
  endfunction

  function automatic int unsigned dly_tap(input logic [2:0] sel,
                                          input int unsigned base,
                                          input int unsigned step);
    int unsigned s;
    s = (int'(sel) > DLY_SEL_MAX) ? DLY_SEL_MAX : int'(sel);
    return base + step * s;
  endfunction

  function automatic int unsigned wd_tap(input logic [1:0] sel,
                                         input int unsigned base,
                                         input int unsigned step);
    return base + step * int'(sel);
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdc_wr,
  input  logic [5:0] wdc_wdata,
  input  logic       dly_wr,
  input  logic [2:0] dly_wdata,
  output logic       wd_en,
  output logic [1:0] wd_sel,
  output logic [2:0] dly_sel,
  output logic       clr
);

  assign clr = wdc_wr && (wdc_wdata[2:0] == WDC_CLR_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_en   <= 1'b0;
      wd_sel  <= 2'd0;
      dly_sel <= 3'd0;
    end else begin
      if (wdc_wr) begin
        wd_en  <= wdc_wdata[5];
        wd_sel <= wdc_wdata[4:3];
      end
      if (dly_wr) dly_sel <= dly_wdata;
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             halt,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (stop || clr) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assert_stop_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (cnt == '0));

  assert_halt_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !stop && !clr) |=> (cnt != $past(cnt)));

endmodule

// File: rtl/wdog_phase.sv
module wdog_phase
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 23,
  parameter int unsigned DLY_BASE = 4,
  parameter int unsigned WD_BASE  = 16,
  parameter int unsigned TAP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wd_en,
  input  logic [1:0]       wd_sel,
  input  logic [2:0]       dly_sel,
  input  logic             clr,
  output logic             osc_ready,
  output logic             wd_irq,
  output logic             sys_rst_req
);

  logic [31:0] cnt_ext;
  logic        stab_hit;
  logic        wd_ovf;
  logic        ovf_pend;

  assign cnt_ext  = 32'(cnt);
  assign stab_hit = tap_rise(cnt_ext, dly_tap(dly_sel, DLY_BASE, TAP_STEP));
  assign wd_ovf   = osc_ready && wd_en &&
                    tap_rise(cnt_ext, wd_tap(wd_sel, WD_BASE, TAP_STEP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_ready   <= 1'b0;
      ovf_pend    <= 1'b0;
      wd_irq      <= 1'b0;
      sys_rst_req <= 1'b0;
    end else if (stop) begin
      osc_ready <= 1'b0;
      ovf_pend  <= 1'b0;
      wd_irq    <= 1'b0;
    end else begin
      wd_irq <= 1'b0;
      if (!osc_ready && stab_hit) osc_ready <= 1'b1;
      if (clr) begin
        ovf_pend <= 1'b0;
      end else if (wd_ovf) begin
        if (!ovf_pend) begin
          ovf_pend <= 1'b1;
          wd_irq   <= 1'b1;
        end else begin
          sys_rst_req <= 1'b1;
        end
      end
    end
  end

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |=> !wd_irq);

  assert_rst_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);

  assert_no_irq_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> osc_ready);

  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_irq) |-> $past(wd_en));

  assert_ready_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_ready) |-> !$past(stop));

endmodule

// File: rtl/wdog_osc_wait.sv
module wdog_osc_wait #(
  parameter int unsigned DLY_BASE = 4,
  parameter int unsigned WD_BASE  = 16,
  parameter int unsigned TAP_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop,
  input  logic       halt,
  input  logic       wdc_wr,
  input  logic [5:0] wdc_wdata,
  input  logic       dly_wr,
  input  logic [2:0] dly_wdata,
  output logic       osc_ready,
  output logic       wd_irq,
  output logic       sys_rst_req
);

  localparam int unsigned CNT_W = WD_BASE + 3 * TAP_STEP + 1;

  logic             wd_en;
  logic [1:0]       wd_sel;
  logic [2:0]       dly_sel;
  logic             clr;
  logic [CNT_W-1:0] cnt;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wdc_wr(wdc_wr), .wdc_wdata(wdc_wdata),
    .dly_wr(dly_wr), .dly_wdata(dly_wdata),
    .wd_en(wd_en), .wd_sel(wd_sel), .dly_sel(dly_sel), .clr(clr)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .stop(stop), .halt(halt), .clr(clr), .cnt(cnt)
  );

  wdog_phase #(
    .CNT_W(CNT_W), .DLY_BASE(DLY_BASE), .WD_BASE(WD_BASE), .TAP_STEP(TAP_STEP)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .stop(stop), .cnt(cnt),
    .wd_en(wd_en), .wd_sel(wd_sel), .dly_sel(dly_sel), .clr(clr),
    .osc_ready(osc_ready), .wd_irq(wd_irq), .sys_rst_req(sys_rst_req)
  );

endmodule

// File: tb/wdog_osc_wait_tb_top.sv
`timescale 1ns/1ps
module wdog_osc_wait_tb_top;

  typedef struct {
    int      kind;   // 0 ready rise, 1 irq cycle, 2 reset request rise
    longint  cyc;
    string   req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop = 1'b0;
  logic       halt = 1'b0;
  logic       wdc_wr = 1'b0;
  logic [5:0] wdc_wdata = '0;
  logic       dly_wr = 1'b0;
  logic [2:0] dly_wdata = '0;
  logic       osc_ready, wd_irq, sys_rst_req;

  int     checks = 0;
  int     errors = 0;
  longint gcyc = 0;
  longint base = 0;
  bit     done = 1'b0;
  exp_t   sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) gcyc <= gcyc + 1;

  wdog_osc_wait #(.DLY_BASE(2), .WD_BASE(6), .TAP_STEP(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop(stop), .halt(halt),
    .wdc_wr(wdc_wr), .wdc_wdata(wdc_wdata),
    .dly_wr(dly_wr), .dly_wdata(dly_wdata),
    .osc_ready(osc_ready), .wd_irq(wd_irq), .sys_rst_req(sys_rst_req)
  );

  task automatic push(input int kind, input longint off, input string req);
    exp_t e;
    e.kind = kind; e.cyc = base + off; e.req = req;
    sb.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, gcyc);
    end
  endtask

  task automatic wait_until(input longint n);
    while (gcyc < n) @(negedge clk);
  endtask

  task automatic write_wdc(input logic [5:0] d);
    wdc_wr = 1'b1; wdc_wdata = d;
    @(negedge clk);
    wdc_wr = 1'b0;
  endtask

  task automatic write_dly(input logic [2:0] d);
    dly_wr = 1'b1; dly_wdata = d;
    @(negedge clk);
    dly_wr = 1'b0;
  endtask

  // monitor: every observed event must match the head of the scoreboard
  bit prev_ready = 1'b0, prev_rst = 1'b0;
  always @(negedge clk) begin
    int kind;
    kind = -1;
    if (osc_ready && !prev_ready) kind = 0;
    if (wd_irq) begin
      if (kind >= 0) begin
        errors++; checks++;
        $display("FAIL R5: actual irq together with ready rise, expected separate (cycle %0d)", gcyc);
      end
      kind = 1;
    end
    if (sys_rst_req && !prev_rst) kind = 2;
    if (kind >= 0) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3/R8 unexpected event", kind, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.kind == kind, e.req, kind, e.kind);
        check(e.cyc == gcyc, e.req, gcyc, e.cyc);
      end
    end
    prev_ready = osc_ready;
    prev_rst   = sys_rst_req;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung run, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (4) @(negedge clk);
    check(!osc_ready, "R10", osc_ready, 0);
    check(!wd_irq, "R10", wd_irq, 0);
    check(!sys_rst_req, "R10", sys_rst_req, 0);

    // A: full sequence, tap 2^2 wait, tap 2^6 watchdog (R1 R2 R4 R5 R6)
    rst_n = 1'b1; base = gcyc;
    write_wdc(6'h20);
    push(0, 5, "R2");
    push(1, 65, "R5");
    push(2, 193, "R6");
    wait_until(base + 250);
    check(sys_rst_req, "R6 sticky", sys_rst_req, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!sys_rst_req, "R6 cleared by reset", sys_rst_req, 0);
    check(!osc_ready, "R10", osc_ready, 0);

    // B: clear code after first irq, HALT held high (R7 R1)
    halt = 1'b1;
    rst_n = 1'b1; base = gcyc;
    write_wdc(6'h20);
    push(0, 5, "R1 halt");
    push(1, 65, "R5");
    wait_until(base + 99);
    write_wdc(6'h25);
    push(1, 165, "R7 pending cleared");
    push(2, 293, "R7 counter cleared");
    wait_until(base + 320);
    halt = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);

    // C: enable left at reset value 0 (R8)
    rst_n = 1'b1; base = gcyc;
    push(0, 5, "R2");
    wait_until(base + 400);
    check(!wd_irq && !sys_rst_req, "R8", sys_rst_req, 0);

    // D: STOP restarts the wait, wait tap 2^4, watchdog tap 2^8 (R9 R2 R4)
    write_dly(3'd1);
    write_wdc(6'h28);
    stop = 1'b1;
    repeat (10) @(negedge clk);
    check(!osc_ready, "R9 ready low in stop", osc_ready, 0);
    stop = 1'b0; base = gcyc;
    push(0, 17, "R9 new wait");
    push(1, 257, "R4 tap select");
    wait_until(base + 300);

    // E: select 7 acts as 5 (tap 2^12); watchdog gated during wait (R2 R3)
    stop = 1'b1;
    @(negedge clk);
    write_dly(3'd7);
    write_wdc(6'h20);
    repeat (3) @(negedge clk);
    stop = 1'b0; base = gcyc;
    push(0, 4097, "R2 select clamp");
    push(1, 4161, "R3 no restart");
    push(2, 4289, "R6");
    wait_until(base + 4350);

    check(sb.size() == 0, "R3 all events seen", sb.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule